// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that can fail a system in two ways. A 7-bit down-counter runs from the peripheral clock through a fixed divider and a selectable power-of-two prescaler. If software lets the counter fall through 0x40, so that bit 6 clears, the block raises a one-cycle system reset request. Software must also refresh at the right time. A refresh that lands while the counter is still above a programmed window value is treated as a fault, and so is any refresh that loads a value below 0x40.

Software reaches the block over a small single-cycle register bus. Writes are taken on a clock edge when select and write-enable are both high. Reads are combinational from the address. The block arms once and stays armed, and only a reset disarms it. One cycle before the deadline, in counter terms, it sets an early-warning flag. That flag drives an interrupt when the interrupt has been enabled.

Top module: `window_watchdog`

## Requirements
- R1: Register map, with unused read bits returning zero. Address 0 (control) holds the counter in bits [6:0] and the arm bit in bit 7. Address 1 (config) holds the window in bits [6:0], the time-base select in bits [8:7] and the warning-interrupt enable in bit 9. Address 2 (status) holds the warning flag in bit 0. After reset the counter is 0x7F, the window is 0x7F, the time base is 0, and the arm bit, the interrupt enable and the flag are all 0.
- R2: The counter decrements once every BASE_DIV × 2^tb clock cycles. The time-base select tb takes the values 0, 1, 2 and 3, which give factors of 1, 2, 4 and 8. A control write loads the counter and restarts the divider chain, so the first decrement comes exactly one full period after the write edge.
- R3: While armed, a decrement from 0x40 to 0x3F raises `wdog_rst_req` in the cycle that follows that clock edge.
- R4: A control write whose counter field is below 0x40 raises `wdog_rst_req` in the next cycle when the block is armed. This includes the case where the same write sets the arm bit.
- R5: A control write made while armed, when the current counter value is above the window value, raises `wdog_rst_req` in the next cycle. The counter still loads the written value.
- R6: A control write made while the counter is at or below the window, with a value of 0x40 or more, loads the counter and raises no reset request.
- R7: Writing 0 to the arm bit does not clear it. While the block is disarmed no reset request is ever raised, even though the counter keeps running and writes below 0x40 are accepted.
- R8: The warning flag sets when the counter decrements from 0x41 to 0x40. This happens whether or not the interrupt is enabled.
- R9: Writing status with bit 0 = 0 clears the warning flag. Writing bit 0 = 1 leaves the flag unchanged.
- R10: Once the interrupt enable is set, a config write with bit 9 = 0 does not clear it. `wdog_irq` equals the warning flag AND the interrupt enable.
- R11: `wdog_rst_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| wdog_rst_req | output | 1 | One-cycle system reset request |
| wdog_irq | output | 1 | Early-warning interrupt |

## Verification
A fault in the divider chain appears on the control read-back within one tick period. The decrement then comes a cycle early or late, so the bench samples the counter one cycle before and one cycle after each expected edge, for every time-base setting. A wrong armed state or a wrong comparison against the window shows up on `wdog_rst_req` in the cycle right after the offending write or tick. The bench therefore samples the reset request at exactly that cycle, and it also keeps a running count of pulses so that any extra or missing request is caught. Flag and enable state that should have survived a write is read back over the bus straight after that write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W = 7;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_FLOOR = cnt_t'(1 << (CNT_W - 1));   // 0x40
    localparam cnt_t CNT_WARN  = CNT_FLOOR + cnt_t'(1);       // 0x41
    localparam cnt_t CNT_INIT  = '1;                          // 0x7F

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_STAT = 2'd2
    } reg_addr_e;

    // field positions within the data word
    localparam int CTRL_ARM_BIT = CNT_W;          // 7
    localparam int CFG_TB_LSB   = CNT_W;          // 7
    localparam int STAT_FLAG_BIT = 0;

    typedef struct packed {
        logic       irq_en;
        logic [1:0] tbase;
        cnt_t       win;
    } cfg_t;

    typedef struct packed {
        logic armed;
        cnt_t cnt;
    } ctrl_t;

    // a counter value that has lost its top bit is past the deadline
    function automatic logic below_floor(input cnt_t v);
        return !v[CNT_W-1];
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int BASE_DIV = 4096,
    parameter int TB_W     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [TB_W-1:0] tbase,
    output logic            tick
);
    localparam int BASE_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int STAGE_W = (1 << TB_W) - 1;
    localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

    logic [BASE_W-1:0]  base_q;
    logic [STAGE_W-1:0] stage_q;
    logic [STAGE_W-1:0] stage_lim;
    logic               base_wrap;
    logic               stage_done;

    // thermometer limit: (2^tbase)-1
    for (genvar i = 0; i < STAGE_W; i++) begin : g_lim
        assign stage_lim[i] = (32'(tbase) > i);
    end

    assign base_wrap  = (base_q == BASE_LAST);
    assign stage_done = (stage_q >= stage_lim);
    assign tick       = base_wrap && stage_done && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            base_q  <= '0;
            stage_q <= '0;
        end else if (base_wrap) begin
            base_q  <= '0;
            stage_q <= stage_done ? '0 : stage_q + STAGE_W'(1);
        end else begin
            base_q  <= base_q + BASE_W'(1);
        end
    end

    // R2: a restart always brings the chain back to its origin
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (base_q == '0 && stage_q == '0));

    // R2: the base divider never leaves its range
    a_r2_base_in_range: assert property (@(posedge clk) disable iff (rst)
        32'(base_q) < BASE_DIV);

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  cnt_t              cnt,
    input  logic              flag_set,
    output cfg_t              cfg,
    output logic              armed,
    output logic              flag,
    output logic              ctrl_wr,
    output ctrl_t             ctrl_wdata
);
    logic wr;
    logic cfg_wr;
    logic stat_wr;
    logic flag_clr;

    assign wr       = bus_sel && bus_we;
    assign ctrl_wr  = wr && (bus_addr == ADDR_CTRL);
    assign cfg_wr   = wr && (bus_addr == ADDR_CFG);
    assign stat_wr  = wr && (bus_addr == ADDR_STAT);
    assign flag_clr = stat_wr && !bus_wdata[STAT_FLAG_BIT];

    assign ctrl_wdata.armed = bus_wdata[CTRL_ARM_BIT];
    assign ctrl_wdata.cnt   = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.win    <= CNT_INIT;
            cfg.tbase  <= '0;
            cfg.irq_en <= 1'b0;
            armed      <= 1'b0;
            flag       <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg.win    <= bus_wdata[CNT_W-1:0];
                cfg.tbase  <= bus_wdata[CFG_TB_LSB +: 2];
                cfg.irq_en <= cfg.irq_en | bus_wdata[CFG_TB_LSB + 2];
            end
            if (ctrl_wr && ctrl_wdata.armed)
                armed <= 1'b1;
            if (flag_set)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CNT_W-1:0]   = cnt;
                bus_rdata[CTRL_ARM_BIT] = armed;
            end
            ADDR_CFG: begin
                bus_rdata[CNT_W-1:0]           = cfg.win;
                bus_rdata[CFG_TB_LSB +: 2]     = cfg.tbase;
                bus_rdata[CFG_TB_LSB + 2]      = cfg.irq_en;
            end
            ADDR_STAT: bus_rdata[STAT_FLAG_BIT] = flag;
            default:   bus_rdata = '0;
        endcase
    end

    // R7: arming is one-way
    a_r7_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R10: interrupt enable is one-way
    a_r10_irq_en_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg.irq_en |=> cfg.irq_en);

    // R9: writing one to the flag leaves a set flag set
    a_r9_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && bus_wdata[STAT_FLAG_BIT] && flag) |=> flag);

    // R8: a warning event always lands in the flag
    a_r8_flag_follows_set: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> flag);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  ctrl_wr,
    input  ctrl_t ctrl_wdata,
    input  logic  armed,
    input  cnt_t  win,
    output cnt_t  cnt,
    output logic  flag_set,
    output logic  rst_req
);
    logic fault_early;
    logic fault_low;
    logic fault_expire;
    logic fault_any;
    logic step;

    assign step         = tick && !ctrl_wr;
    assign fault_early  = ctrl_wr && armed && (cnt > win);
    assign fault_low    = ctrl_wr && (armed || ctrl_wdata.armed) && below_floor(ctrl_wdata.cnt);
    assign fault_expire = step && armed && (cnt == CNT_FLOOR);
    assign fault_any    = fault_early || fault_low || fault_expire;
    assign flag_set     = step && (cnt == CNT_WARN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_INIT;
            rst_req <= 1'b0;
        end else begin
            if (ctrl_wr)
                cnt <= ctrl_wdata.cnt;
            else if (tick)
                cnt <= cnt - cnt_t'(1);
            rst_req <= fault_any && !rst_req;
        end
    end

    // R11: request is a single-cycle pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7: nothing is requested while disarmed
    a_r7_silent_disarmed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !(ctrl_wr && ctrl_wdata.armed)) |=> !rst_req);

    // R3: crossing the floor while armed requests reset
    a_r3_expiry: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl_wr && armed && !rst_req && cnt == CNT_FLOOR) |=> (rst_req && cnt == CNT_FLOOR - cnt_t'(1)));

    // R5: a refresh above the window requests reset
    a_r5_early_refresh: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && armed && !rst_req && cnt > win) |=> rst_req);

    // R2: the counter holds between ticks and writes
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_wr) |=> $stable(cnt));

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wdog_pkg::*;
#(
    parameter int BASE_DIV = 4096,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst_req,
    output logic              wdog_irq
);
    localparam int TB_W = 2;

    cfg_t  cfg;
    ctrl_t ctrl_wdata;
    cnt_t  cnt;
    logic  armed;
    logic  flag;
    logic  flag_set;
    logic  ctrl_wr;
    logic  tick;

    wdog_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt        (cnt),
        .flag_set   (flag_set),
        .cfg        (cfg),
        .armed      (armed),
        .flag       (flag),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata)
    );

    wdog_prescaler #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_wr),
        .tbase   (cfg.tbase),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .armed      (armed),
        .win        (cfg.win),
        .cnt        (cnt),
        .flag_set   (flag_set),
        .rst_req    (wdog_rst_req)
    );

    assign wdog_irq = flag && cfg.irq_en;

    // R10: interrupt line never rises without the enable
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
        wdog_irq |-> cfg.irq_en);

endmodule

// File: tb/window_watchdog_tb.sv
module window_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_DIV   = 16;
    localparam int N0         = BASE_DIV;
    localparam int WD_LIMIT   = 20000;

    // time-base vectors: {tb select, expected period in cycles}
    localparam int NVEC = 4;
    localparam int TB_VEC  [NVEC] = '{0, 1, 2, 3};
    localparam int PER_VEC [NVEC] = '{16, 32, 64, 128};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_req;
    logic        wdog_irq;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cycles = 0;

    window_watchdog #(.BASE_DIV(BASE_DIV), .DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst_req(wdog_rst_req), .wdog_irq(wdog_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && wdog_rst_req) pulses++;
        cycles++;
        if (cycles > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] rd;
    int          p0;

    initial begin
        wait_edges(3);
        rst = 1'b0;
        wait_edges(1);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl reset", rd, 32'h7F);
        bus_read(2'd1, rd); check("R1 cfg reset", rd, 32'h7F);
        bus_read(2'd2, rd); check("R1 status reset", rd, 32'h0);
        check("R1 no request at reset", 32'(wdog_rst_req), 32'd0);
        check("R1 no irq at reset", 32'(wdog_irq), 32'd0);

        // R2 tick spacing for every time base (disarmed)
        for (int v = 0; v < NVEC; v++) begin
            bus_write(2'd1, 32'h7F | (32'(TB_VEC[v]) << 7));
            bus_write(2'd0, 32'h7F);
            wait_edges(PER_VEC[v] - 1);
            bus_read(2'd0, rd); check("R2 before first tick", rd, 32'h7F);
            wait_edges(1);
            bus_read(2'd0, rd); check("R2 first tick", rd, 32'h7E);
            wait_edges(PER_VEC[v] - 1);
            bus_read(2'd0, rd); check("R2 before second tick", rd, 32'h7E);
            wait_edges(1);
            bus_read(2'd0, rd); check("R2 second tick", rd, 32'h7D);
        end

        // R7 disarmed write below floor is accepted silently
        p0 = pulses;
        bus_write(2'd0, 32'h30);
        check("R7 no request disarmed low write", 32'(wdog_rst_req), 32'd0);
        bus_read(2'd0, rd); check("R7 counter loads 0x30", rd, 32'h30);

        // R7/R8 disarmed expiry: flag sets, no request
        bus_write(2'd1, 32'h7F);
        bus_write(2'd0, 32'h41);
        wait_edges(N0);
        bus_read(2'd2, rd); check("R8 flag sets without irq enable", rd, 32'h1);
        check("R10 irq low without enable", 32'(wdog_irq), 32'd0);
        wait_edges(N0);
        bus_read(2'd0, rd); check("R7 counter passes floor", rd, 32'h3F);
        check("R7 no pulses while disarmed", 32'(pulses - p0), 32'd0);

        // R9 flag write semantics
        bus_write(2'd2, 32'h1);
        bus_read(2'd2, rd); check("R9 write one keeps flag", rd, 32'h1);
        bus_write(2'd2, 32'h0);
        bus_read(2'd2, rd); check("R9 write zero clears flag", rd, 32'h0);

        // R6 arming refresh within window
        p0 = pulses;
        bus_write(2'd0, 32'h80 | 32'h7F);
        check("R6 arming refresh no request", 32'(wdog_rst_req), 32'd0);
        bus_read(2'd0, rd); check("R6 armed and loaded", rd, 32'hFF);

        // R5 early refresh above window
        bus_write(2'd1, 32'h50);
        bus_write(2'd0, 32'h80 | 32'h7F);
        check("R5 early refresh request", 32'(wdog_rst_req), 32'd1);
        wait_edges(1);
        check("R11 request drops after one cycle", 32'(wdog_rst_req), 32'd0);

        // R7 arm bit cannot be cleared
        bus_write(2'd1, 32'h7F);
        bus_write(2'd0, 32'h7F);
        check("R7 no request on in-window write", 32'(wdog_rst_req), 32'd0);
        bus_read(2'd0, rd); check("R7 arm bit still set", rd, 32'hFF);

        // R4 armed write below floor
        bus_write(2'd0, 32'h80 | 32'h3F);
        check("R4 low write request", 32'(wdog_rst_req), 32'd1);
        wait_edges(1);
        check("R11 low-write pulse width", 32'(wdog_rst_req), 32'd0);

        // R3/R8/R10 armed expiry with interrupt enabled
        bus_write(2'd1, 32'h27F);
        bus_write(2'd0, 32'h80 | 32'h41);
        wait_edges(N0 - 1);
        bus_read(2'd0, rd); check("R8 counter before warn", rd, 32'hC1);
        check("R8 irq not yet", 32'(wdog_irq), 32'd0);
        wait_edges(1);
        bus_read(2'd2, rd); check("R8 flag at 0x40", rd, 32'h1);
        check("R10 irq follows flag", 32'(wdog_irq), 32'd1);
        wait_edges(N0 - 1);
        check("R3 no request before expiry", 32'(wdog_rst_req), 32'd0);
        wait_edges(1);
        check("R3 expiry request", 32'(wdog_rst_req), 32'd1);
        bus_read(2'd0, rd); check("R3 counter 0x3F", rd, 32'hBF);
        wait_edges(1);
        check("R11 expiry pulse width", 32'(wdog_rst_req), 32'd0);

        // R10 enable survives a zero write; clearing flag drops irq
        bus_write(2'd1, 32'h60);
        bus_read(2'd1, rd); check("R10 irq enable sticky", rd, 32'h260);
        bus_write(2'd2, 32'h0);
        check("R10 irq low after flag clear", 32'(wdog_irq), 32'd0);

        // R6 refresh exactly at window, then R5 above it
        bus_write(2'd0, 32'h80 | 32'h60);
        check("R6 refresh below window", 32'(wdog_rst_req), 32'd0);
        bus_write(2'd0, 32'h80 | 32'h70);
        check("R6 refresh at window equal", 32'(wdog_rst_req), 32'd0);
        bus_write(2'd0, 32'h80 | 32'h70);
        check("R5 refresh above window", 32'(wdog_rst_req), 32'd1);
        bus_read(2'd0, rd); check("R5 counter still loads", rd, 32'hF0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule